// File: doc/BRIEF.md
# Dual-Role Byte SPI Controller

This block is an 8-bit SPI engine that can act as the bus master or as a slave. A single configuration byte sets its role and its interrupt source. In master mode it also sets the bit-clock divider, and in slave mode it sets where the select comes from. Another bit in the same byte lets the pin inputs skip the two-flop synchronizer. A separate enable bit starts the engine. While the engine is enabled, the configuration byte is frozen.

Software talks to the block through a small register port. Address 0 holds the configuration and address 1 holds the enable bit. A write to address 2 loads the transmit buffer; a read there returns status. Address 3 returns the last received byte. The transmit buffer is one byte deep and is emptied as soon as its content is copied into the shift register. Software can therefore queue the next byte while the current one is still on the wire. A master that finds a queued byte at the end of a transfer continues without a gap. Bytes go out MSB first in SPI mode 0: the clock idles low, data changes on the falling edge and is sampled on the rising edge.

Top module: `spi_dual_role`

## Requirements
- R1: In master mode, configuration bits [7:5] hold the divider code d. The period of `sclk_o` is 2^(d+1) system clocks, for d = 0 to 7.
- R2: Configuration bit 4 = 1 feeds the pins straight into the engine. Bit 4 = 0 passes every pin input through two system-clock flops. With the bypass, a master loops back correctly at d = 0. With the synchronizer, it loops back correctly at d >= 2.
- R3: When configuration bit 2 = 0, the slave is selected from configuration bit 3: 0 selects, 1 deselects, and the `ss_n_i` pin is ignored. While deselected this way, clock pulses neither complete a byte nor change the receive register.
- R4: When configuration bit 2 = 1, the slave is selected while `ss_n_i` is low.
- R5: `irq` is low while disabled. When enabled, it follows the tx-empty flag if configuration bit 1 = 0, and the done flag if bit 1 = 1.
- R6: Configuration bit 0 = 0 selects master and 1 selects slave. A slave never drives `sclk_o`, and it shifts its transmit byte out on `miso_o` MSB first.
- R7: After reset, address 0 reads 0x00, the status at address 2 reads 0x02 (bit 1 = tx empty, bit 0 = done), address 3 reads 0x00 and `irq` is low.
- R8: Writes to address 0 are ignored while the enable bit (address 1, bit 0) is 1.
- R9: A master shifts data MSB first on `mosi_o`, changing it only while `sclk_o` is low. `sclk_o` is low whenever no transfer is running.
- R10: After the eighth bit, the received byte appears at address 3 and the done flag is set. A write to address 2 clears done.
- R11: A slave that is deselected in the middle of a byte drops the partial byte and restarts its bit count. Done is not set for the dropped byte.
- R12: Tx-empty is set once the buffered byte is copied into the shift register. A master that finds a byte queued at the end of a transfer starts the next byte with no gap in the bit-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sclk_i | input | 1 | Bit clock from an external master (slave mode) |
| sclk_o | output | 1 | Bit clock driven in master mode |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| ss_n_i | input | 1 | Active-low slave-select pin |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is a slave losing its select partway through a byte. The stimulus must stop mid-byte, and the following byte must still be framed and transmitted correctly. The bench drives three clock pulses, raises the select pin, and checks that done stays low. It then queues a new byte and clocks a full frame, checking both the received byte and the bits shifted out. Gap-free back-to-back transfers are reached by queueing the second byte as soon as tx-empty rises. The bench then measures the largest interval between rising clock edges across all sixteen bits.

// File: rtl/spi_dual_role.sv
module spi_dual_role #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              sclk_i,
  output logic              sclk_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              miso_o,
  input  logic              ss_n_i,
  output logic              irq
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam int BIT_W = $clog2(DATA_W);

  logic [7:0]        cfg;
  logic              en;
  logic [DATA_W-1:0] txbuf, shift, rx;
  logic              tx_empty, done, samp, loaded, busy, sclk_d;
  logic [BIT_W-1:0]  bitcnt;
  logic [CNT_W-1:0]  div_cnt;
  logic [3:0]        sync1, sync2;

  wire [DIV_W-1:0] div_sel = cfg[7:5];
  wire bypass  = cfg[4];
  wire ss_lvl  = cfg[3];
  wire ss_pin  = cfg[2];
  wire on_done = cfg[1];
  wire slave   = cfg[0];

  wire [3:0] pins  = {sclk_i, mosi_i, miso_i, ss_n_i};
  wire [3:0] pin_q = bypass ? pins : sync2;
  wire sclk_q = pin_q[3];
  wire din    = slave ? pin_q[2] : pin_q[1];
  wire sel    = en & slave & (ss_pin ? ~pin_q[0] : ~ss_lvl);

  wire [CNT_W-1:0] half_m1 = CNT_W'((CNT_W+1)'(1) << div_sel) - CNT_W'(1);
  wire tick = busy && (div_cnt == half_m1);
  wire rise = slave ? (sel & sclk_q & ~sclk_d) : (tick & ~sclk_o);
  wire fall = slave ? (sel & ~sclk_q & sclk_d) : (tick & sclk_o);
  wire last = fall && (bitcnt == BIT_W'(DATA_W-1));

  wire load_m = en & ~slave & ~busy & ~tx_empty;
  wire load_n = last & ~slave & ~tx_empty;
  wire load_s = en & slave & ~loaded & (bitcnt == '0) & ~tx_empty;

  assign mosi_o = slave ? 1'b0 : shift[DATA_W-1];
  assign miso_o = slave ? shift[DATA_W-1] : 1'b0;
  assign irq    = en & (on_done ? done : tx_empty);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = cfg;
      2'd1:    reg_rdata = {7'd0, en};
      2'd2:    reg_rdata = {6'd0, tx_empty, done};
      default: reg_rdata = 8'(rx);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sclk_d <= 1'b0;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
      sclk_d <= sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; en <= 1'b0; txbuf <= '0; tx_empty <= 1'b1; done <= 1'b0;
      rx <= '0; shift <= '0; samp <= 1'b0; bitcnt <= '0; loaded <= 1'b0;
      busy <= 1'b0; sclk_o <= 1'b0; div_cnt <= '0;
    end else begin
      if (!en) begin
        busy <= 1'b0; sclk_o <= 1'b0; div_cnt <= '0; bitcnt <= '0; loaded <= 1'b0;
      end else begin
        if (busy) div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) sclk_o <= ~sclk_o;
        if (rise) samp <= din;
        if (fall) begin
          shift  <= {shift[DATA_W-2:0], samp};
          bitcnt <= bitcnt + 1'b1;
        end
        if (last) begin
          rx <= {shift[DATA_W-2:0], samp};
          done <= 1'b1; loaded <= 1'b0; busy <= 1'b0;
        end
        if (slave && !sel) begin
          bitcnt <= '0;
          if (bitcnt != '0) loaded <= 1'b0;
        end
        if (load_m || load_n || load_s) begin
          shift <= txbuf; tx_empty <= 1'b1;
        end
        if (load_m || load_n) begin
          busy <= 1'b1; div_cnt <= '0;
        end
        if (load_s) loaded <= 1'b1;
      end
      if (reg_wr) begin
        case (reg_addr)
          2'd0: if (!en) cfg <= reg_wdata;
          2'd1: en <= reg_wdata[0];
          2'd2: begin txbuf <= DATA_W'(reg_wdata); tx_empty <= 1'b0; done <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) en |=> $stable(cfg)); // R8
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk_o); // R9
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(bitcnt) == BIT_W'(DATA_W-1)); // R10
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (slave && !sel) |=> bitcnt == '0); // R11
  AST_SLAVE_NO_SCLK: assert property (@(posedge clk) disable iff (!rst_n) slave |-> !sclk_o); // R6
endmodule

// File: tb/spi_dual_role_tb.sv
module spi_dual_role_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic sclk_i = 0, mosi_i = 0, ss_n_i = 1;
  logic sclk_o, mosi_o, miso_o, irq;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_dual_role u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_i(sclk_i), .sclk_o(sclk_o),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .miso_i(mosi_o), .miso_o(miso_o),
    .ss_n_i(ss_n_i), .irq(irq));

  logic mon_clr = 0, mon_prev = 0;
  logic [7:0] mon_byte = 0;
  int mon_cnt = 0, cyc = 0, last_rise = 0, max_gap = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mon_prev <= sclk_o;
    if (mon_clr) begin
      mon_cnt <= 0; max_gap <= 0;
    end else if (sclk_o && !mon_prev) begin
      mon_byte <= {mon_byte[6:0], mosi_o};
      mon_cnt <= mon_cnt + 1;
      if (mon_cnt > 0 && cyc - last_rise > max_gap) max_gap <= cyc - last_rise;
      last_rise <= cyc;
    end
  end

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  function automatic logic [7:0] mk_cfg(int code, bit byp, bit lvl, bit pin, bit ion, bit slv);
    return {code[2:0], byp, lvl, pin, ion, slv};
  endfunction

  task automatic wait_flag(int idx, int lim, output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      rd(2'd2, s);
      if (s[idx]) begin ok = 1; break; end
    end
  endtask

  task automatic pulse_mon_clr();
    @(negedge clk); mon_clr = 1; @(negedge clk); mon_clr = 0;
  endtask

  task automatic master_xfer(int code, bit byp, logic [7:0] b, bit ion);
    logic [7:0] d; bit ok;
    wr(2'd1, 8'h00);
    wr(2'd0, mk_cfg(code, byp, 1'b0, 1'b1, ion, 1'b0));
    wr(2'd1, 8'h01);
    pulse_mon_clr();
    wr(2'd2, b);
    wait_flag(0, 6000, ok);
    check("R10 done set", ok, 1);
    rd(2'd3, d);
    check(byp ? "R2 bypass loopback" : "R2 sync loopback", d, b);
    check("R9 msb first on mosi", mon_byte, b);
    check("R1 sclk period", max_gap, 2 << code);
    check("R9 sclk idle low", sclk_o, 0);
    check("R5 irq source", irq, 1);
  endtask

  task automatic slave_bits(logic [7:0] m, int n, output logic [7:0] got);
    got = 0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); mosi_i = m[i];
      repeat (8) @(negedge clk);
      got = {got[6:0], miso_o};
      sclk_i = 1;
      repeat (8) @(negedge clk);
      sclk_i = 0;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got, t, m; bit ok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, d); check("R7 cfg reset", d, 8'h00);
    rd(2'd2, d); check("R7 status reset", d, 8'h02);
    rd(2'd3, d); check("R7 rx reset", d, 8'h00);
    check("R7 irq reset", irq, 0);

    wr(2'd0, 8'h31); wr(2'd1, 8'h01);
    wr(2'd0, 8'hCE);
    rd(2'd0, d); check("R8 cfg frozen while enabled", d, 8'h31);
    wr(2'd1, 8'h00);
    check("R5 irq low when disabled", irq, 0);

    master_xfer(0, 1, 8'hA5, 1);
    master_xfer(2, 0, 8'h3C, 0);
    master_xfer(7, 1, 8'h81, 1);
    for (int k = 0; k < 16; k++) begin
      bit byp = 1'($urandom);
      int code = byp ? int'($urandom_range(0, 6)) : int'($urandom_range(2, 6));
      master_xfer(code, byp, 8'($urandom), 1'($urandom));
    end

    // R12 back-to-back
    wr(2'd1, 8'h00);
    wr(2'd0, mk_cfg(2, 1, 0, 1, 1, 0));
    wr(2'd1, 8'h01);
    pulse_mon_clr();
    wr(2'd2, 8'h5A);
    wait_flag(1, 20, ok);
    check("R12 tx empty after copy", ok, 1);
    check("R12 still mid byte", mon_cnt < 8, 1);
    wr(2'd2, 8'hC3);
    wait_flag(0, 2000, ok);
    rd(2'd3, d); check("R12 first byte", d, 8'h5A);
    for (int i = 0; i < 4000 && mon_cnt < 16; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    rd(2'd3, d); check("R12 second byte", d, 8'hC3);
    check("R12 no gap", max_gap, 8);

    // R5 tx-empty source vs done source
    wr(2'd1, 8'h00);
    wr(2'd0, mk_cfg(0, 1, 1, 0, 0, 1));
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h11);
    repeat (3) @(negedge clk);
    check("R5 irq on tx empty", irq, 1);
    wr(2'd1, 8'h00);
    wr(2'd0, mk_cfg(0, 1, 1, 0, 1, 1));
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h11);
    repeat (3) @(negedge clk);
    check("R5 irq on done not yet", irq, 0);

    // R4 R6 pin select slave
    for (int k = 0; k < 6; k++) begin
      bit byp = 1'($urandom);
      t = 8'($urandom); m = 8'($urandom);
      wr(2'd1, 8'h00);
      wr(2'd0, mk_cfg(0, byp, 1, 1, 1, 1));
      wr(2'd1, 8'h01);
      wr(2'd2, t);
      repeat (4) @(negedge clk);
      ss_n_i = 0;
      slave_bits(m, 8, got);
      ss_n_i = 1;
      repeat (4) @(negedge clk);
      rd(2'd3, d); check("R4 slave rx", d, m);
      check("R6 slave miso msb first", got, t);
      check("R6 slave leaves sclk_o low", sclk_o, 0);
      check("R5 irq on done", irq, 1);
    end

    // R11 abort
    wr(2'd2, 8'h96);
    repeat (4) @(negedge clk);
    ss_n_i = 0;
    slave_bits(8'hFF, 3, got);
    ss_n_i = 1;
    repeat (6) @(negedge clk);
    rd(2'd2, d); check("R11 no done after abort", d[0], 0);
    wr(2'd2, 8'h4B);
    repeat (4) @(negedge clk);
    ss_n_i = 0;
    slave_bits(8'h2D, 8, got);
    ss_n_i = 1;
    repeat (6) @(negedge clk);
    rd(2'd3, d); check("R11 rx after abort", d, 8'h2D);
    check("R11 miso after abort", got, 8'h4B);

    // R3 internal select
    wr(2'd1, 8'h00);
    wr(2'd0, mk_cfg(0, 0, 0, 0, 1, 1));
    wr(2'd1, 8'h01);
    wr(2'd2, 8'hE7);
    ss_n_i = 1;
    repeat (4) @(negedge clk);
    slave_bits(8'h69, 8, got);
    rd(2'd3, d); check("R3 internal select rx", d, 8'h69);
    check("R3 internal select miso", got, 8'hE7);
    wr(2'd1, 8'h00);
    wr(2'd0, mk_cfg(0, 0, 1, 0, 1, 1));
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h00);
    ss_n_i = 0;
    slave_bits(8'h12, 8, got);
    ss_n_i = 1;
    rd(2'd2, d); check("R3 deselected no done", d[0], 0);
    rd(2'd3, d); check("R3 deselected rx kept", d, 8'h69);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule